// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a field-configurable sum-of-products engine. A 16-bit data word enters an AND plane of 32 product terms. Each term can take the true or the complemented form of any input. An OR plane then gathers any subset of those terms into each of 8 outputs. A last stage can invert each output. Any term may feed several outputs, so one product is built once and shared.

The whole personality is a single 1288-bit configuration word. It enters one bit per clock on a serial pin while the load enable is high, most significant bit first. During loading the outputs are forced low. Once loading stops, the configuration holds. The outputs are the registered result of the combinational array evaluated on the current data word.

Top module: `pla_array`

## Requirements
- R1: A synchronous active-high reset clears the whole configuration word to zero and drives `f_out` to zero; after reset with no load, `f_out` stays zero for any data.
- R2: While `load_en` is high, each rising clock edge shifts `cfg_sdi` into configuration bit 0 and moves every bit one place up, so after 1288 shifts the first bit sent sits at bit 1287 (most significant bit first).
- R3: In the cycle after any edge at which `load_en` was high, `f_out` is zero.
- R4: Term t is the AND of its enabled literals: configuration bit 2*(16*t+i) enables input i in true form, and bit 2*(16*t+i)+1 enables it in complemented form.
- R5: A term with no literal enabled evaluates to 1, but it affects only the outputs it is connected to.
- R6: A term with both literals of the same input enabled evaluates to 0.
- R7: Configuration bit 1024+32*o+t connects term t to the OR of output o; an output with no connected term is 0 before the polarity stage.
- R8: One term may be connected to several outputs at once, and each of those outputs uses it.
- R9: Configuration bit 1280+o inverts output o after its OR.
- R10: While `load_en` is low, `f_out` at a rising edge takes the array result for the `data_in` present just before that edge, and holds between edges.
- R11: While `load_en` is low, the configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Shift configuration in while high |
| cfg_sdi | input | 1 | Serial configuration bit, most significant first |
| data_in | input | 16 | Array input literals |
| f_out | output | 8 | Registered sum-of-products results |

## Verification
Each result is due one rising edge after its stimulus. A data word presented before an edge shows up on `f_out` after that edge. The zero forced during a load also appears one edge after `load_en` rises. A configuration is usable from the first edge after `load_en` falls. The bench drives every input on the falling edge and reads `f_out` at the following falling edge, one full register stage later. It also reads once just after a data change, before the edge, to confirm the previous result is still held.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Position of the enable bit for one literal of one term inside the AND plane.
  function automatic int lit_bit(input int term, input int inp, input int n_in, input bit cmp);
    return 2 * (term * n_in + inp) + (cmp ? 1 : 0);
  endfunction

  // Position of the connection bit for one term into one output, relative to the OR plane.
  function automatic int conn_bit(input int out, input int term, input int n_term);
    return out * n_term + term;
  endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
  parameter int W = 1288
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sdi,
  output logic [W-1:0] cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (shift_en) begin
      cfg_q <= {cfg_q[W-2:0], sdi};
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 32,
  localparam int LIT_W = 2 * N_IN * N_TERM
) (
  input  logic [N_IN-1:0]   x,
  input  logic [LIT_W-1:0]  lit_en,
  output logic [N_TERM-1:0] term
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] miss;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      localparam int POS_T = lit_bit(t, i, N_IN, 1'b0);
      localparam int POS_C = lit_bit(t, i, N_IN, 1'b1);
      // a literal blocks the product when its enabled form is false
      assign miss[i] = (lit_en[POS_T] & ~x[i]) | (lit_en[POS_C] & x[i]);
    end
    assign term[t] = ~|miss;
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int N_TERM = 32,
  parameter int N_OUT  = 8,
  localparam int CONN_W = N_TERM * N_OUT
) (
  input  logic [N_TERM-1:0] term,
  input  logic [CONN_W-1:0] conn,
  input  logic [N_OUT-1:0]  invert,
  output logic [N_OUT-1:0]  f
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel;
    for (genvar t = 0; t < N_TERM; t++) begin : g_sel
      localparam int POS = conn_bit(o, t, N_TERM);
      assign sel[t] = conn[POS] & term[t];
    end
    assign f[o] = (|sel) ^ invert[o];
  end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 32,
  parameter int N_OUT  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             cfg_sdi,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_OUT-1:0] f_out
);

  localparam int AND_W = 2 * N_IN * N_TERM;
  localparam int OR_W  = N_TERM * N_OUT;
  localparam int CFG_W = AND_W + OR_W + N_OUT;

  logic [CFG_W-1:0]  cfg_q;
  logic [N_TERM-1:0] term_w;
  logic [N_OUT-1:0]  eval_w;

  pla_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (load_en),
    .sdi      (cfg_sdi),
    .cfg_q    (cfg_q)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .x      (data_in),
    .lit_en (cfg_q[AND_W-1:0]),
    .term   (term_w)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term   (term_w),
    .conn   (cfg_q[AND_W +: OR_W]),
    .invert (cfg_q[AND_W+OR_W +: N_OUT]),
    .f      (eval_w)
  );

  always_ff @(posedge clk) begin
    if (rst || load_en) begin
      f_out <= '0;
    end else begin
      f_out <= eval_w;
    end
  end

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_OUT = 8,
  parameter int CFG_W = 1288
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic             cfg_sdi,
  input logic [CFG_W-1:0] cfg_q,
  input logic [N_OUT-1:0] eval_w,
  input logic [N_OUT-1:0] f_out
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (f_out == '0) && (cfg_q == '0));

  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cfg_q[0] == $past(cfg_sdi));

  a_r3_zero_in_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> f_out == '0);

  a_r10_out_follows: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> f_out == $past(eval_w));

  a_r11_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(cfg_q));

endmodule

bind pla_array pla_array_chk #(.N_OUT(N_OUT), .CFG_W(CFG_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_en (load_en),
  .cfg_sdi (cfg_sdi),
  .cfg_q   (cfg_q),
  .eval_w  (eval_w),
  .f_out   (f_out)
);

// File: tb/pla_array_test.sv
module pla_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 16;
  localparam int NT = 32;
  localparam int NO = 8;
  localparam int AW = 2 * NI * NT;
  localparam int OW = NT * NO;
  localparam int CW = AW + OW + NO;

  logic clk = 1'b0;
  logic rst, load_en, cfg_sdi;
  logic [NI-1:0] data_in;
  logic [NO-1:0] f_out;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) uut (
    .clk(clk), .rst(rst), .load_en(load_en), .cfg_sdi(cfg_sdi),
    .data_in(data_in), .f_out(f_out)
  );

  task automatic check(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // configuration field helpers, positions per R4, R7, R9
  function automatic logic [CW-1:0] with_lit(input logic [CW-1:0] c, input int t, input int i, input bit cmp);
    c[2*(NI*t+i) + (cmp ? 1 : 0)] = 1'b1;
    return c;
  endfunction

  function automatic logic [CW-1:0] with_conn(input logic [CW-1:0] c, input int o, input int t);
    c[AW + NT*o + t] = 1'b1;
    return c;
  endfunction

  function automatic logic [CW-1:0] with_inv(input logic [CW-1:0] c, input int o);
    c[AW + OW + o] = 1'b1;
    return c;
  endfunction

  // expected array result computed from the requirement text
  function automatic logic [NO-1:0] model(input logic [CW-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] tv;
    logic [NO-1:0] r;
    for (int t = 0; t < NT; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[2*(NI*t+i)] && !x[i]) tv[t] = 1'b0;
        if (c[2*(NI*t+i)+1] && x[i]) tv[t] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < NT; t++) if (c[AW + NT*o + t] && tv[t]) r[o] = 1'b1;
      r[o] = r[o] ^ c[AW + OW + o];
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] rand_cfg();
    logic [CW-1:0] c = '0;
    for (int t = 0; t < NT; t++) begin
      for (int k = 0; k < 3; k++) c = with_lit(c, t, int'($urandom_range(NI-1)), 1'($urandom_range(1)));
    end
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NT; t++) if ($urandom_range(3) == 0) c = with_conn(c, o, t);
      if ($urandom_range(1) == 1) c = with_inv(c, o);
    end
    return c;
  endfunction

  // called at a falling edge, returns at a falling edge with load_en low
  task automatic load(input logic [CW-1:0] c);
    for (int b = CW-1; b >= 0; b--) begin
      load_en = 1'b1;
      cfg_sdi = c[b];
      @(negedge clk);
      if (b == CW-4 || b == 2) check("R3 output zero while loading", f_out, '0);
    end
    load_en = 1'b0;
    cfg_sdi = 1'b0;
  endtask

  task automatic apply(input string req, input logic [NI-1:0] x, input logic [NO-1:0] exp);
    data_in = x;
    @(negedge clk);
    check(req, f_out, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] c;
    logic [NI-1:0] x;
    logic f1, f2, x1, x2, x3;
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; load_en = 1'b0; cfg_sdi = 1'b0; data_in = '0;
    @(negedge clk); @(negedge clk);
    check("R1 reset output", f_out, '0);
    rst = 1'b0;
    apply("R1 empty config after reset", 16'hffff, '0);
    apply("R1 empty config after reset", 16'h1234, '0);

    // two shared-term functions, R2 R4 R7 R8
    c = '0;
    c = with_lit(c, 0, 0, 0); c = with_lit(c, 0, 1, 0);                          // x1 x2
    c = with_lit(c, 1, 0, 0); c = with_lit(c, 1, 2, 1);                          // x1 x3'
    c = with_lit(c, 2, 0, 1); c = with_lit(c, 2, 1, 1); c = with_lit(c, 2, 2, 0); // x1' x2' x3
    c = with_lit(c, 3, 0, 0); c = with_lit(c, 3, 2, 0);                          // x1 x3
    c = with_conn(c, 0, 0); c = with_conn(c, 0, 1); c = with_conn(c, 0, 2);
    c = with_conn(c, 1, 0); c = with_conn(c, 1, 2); c = with_conn(c, 1, 3);
    load(c);
    for (int v = 0; v < 8; v++) begin
      x = 16'($urandom) & 16'hfff8 | 16'(v);
      x1 = x[0]; x2 = x[1]; x3 = x[2];
      f1 = (x1 & x2) | (x1 & !x3) | (!x1 & !x2 & x3);
      f2 = (x1 & x2) | (!x1 & !x2 & x3) | (x1 & x3);
      apply("R8 R2 shared terms f1 f2", x, {6'b0, f2, f1});
    end
    // held between edges, R10
    data_in = 16'h0003;
    @(negedge clk);
    data_in = 16'h0000;
    #1 check("R10 output held before edge", f_out, 8'h03);
    @(negedge clk);
    check("R10 output after edge", f_out, 8'h00);

    // corner terms: R5 R6 R7 R9
    c = '0;
    c = with_inv(c, 2);                                       // no terms, inverted -> 1
    c = with_conn(c, 3, 5);                                   // empty term -> 1
    c = with_lit(c, 6, 5, 0); c = with_lit(c, 6, 5, 1);       // x5 x5' -> 0
    c = with_conn(c, 4, 6);
    c = with_conn(c, 5, 6); c = with_inv(c, 5);
    c = with_conn(c, 6, 5); c = with_inv(c, 6);
    // term 7 empty but unconnected, out 7 nothing
    load(c);
    apply("R5 R6 R7 R9 corner terms", 16'h0000, 8'h2c);
    apply("R5 R6 R7 R9 corner terms", 16'h0020, 8'h2c);
    apply("R6 contradictory literals", 16'hffff, 8'h2c);
    for (int k = 0; k < 20; k++) apply("R11 config holds", 16'($urandom), 8'h2c);

    // random personalities, R4 R7 R8 R9
    for (int n = 0; n < 3; n++) begin
      c = rand_cfg();
      load(c);
      for (int k = 0; k < 150; k++) begin
        x = 16'($urandom);
        apply("R4 R7 random array", x, model(c, x));
      end
    end

    // reset after use clears the configuration, R1
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after use", f_out, '0);
    rst = 1'b0;
    apply("R1 config cleared", 16'hffff, '0);
    apply("R1 config cleared", 16'h0000, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule